// File: doc/BRIEF.md
# Digit-Aligned Pipelined Significand Adder

This block adds two operands that are held in a wide-digit floating form. Each operand is a two's-complement significand of `54 + 2^BASE_LG2` bits paired with a short exponent of `11 - BASE_LG2` bits. One exponent step stands for one digit of `2^BASE_LG2` bits, so the exponent compare stays narrow. The unit finds the larger exponent and shifts the other significand right by whole digits, keeping its sign. It then adds the two aligned significands. If the sum spills into the guard bit, the unit moves the sum down by one digit and raises the exponent by one.

The wide integer add is cut into `SLICE_W`-bit slices. A register sits on the carry between each slice and the next. The slice operands travel down the pipeline with the partial sum, so each slice meets the carry from the slice below it in the right cycle. The exponent and the valid flag move in step with the data. A result leaves the unit a fixed number of cycles after its operands enter, and a new operand pair can enter on every clock. At the default base of 64 the significand is 118 bits wide and is split into three slices, so the latency is 3 cycles.

Top module: `digit_align_add`

## Requirements
- R1: `out_vld` goes high exactly LAT = ceil(SIG_W/SLICE_W) clock cycles after each cycle in which `in_vld` is high, and is low otherwise. At the defaults, LAT is 3.
- R2: The result exponent is the larger of `in_exp_a` and `in_exp_b`, compared as unsigned EXP_W-bit values (5 bits at the defaults). It is raised by one only under R6.
- R3: The operand with the larger exponent enters the add unchanged. When the exponents are equal, operand A counts as the larger one and neither operand is shifted. The other operand is shifted right arithmetically by DIGIT × (difference) bits, where DIGIT = 2^BASE_LG2 = 64.
- R4: A shift of SIG_W bits or more turns the shifted operand into all zeros if it was non-negative and into all ones (−1) if it was negative.
- R5: The raw sum is the SIG_W-bit two's-complement sum of the two aligned operands.
- R6: If bits [SIG_W-1] and [SIG_W-2] of the raw sum differ, the output significand is the raw sum shifted right arithmetically by DIGIT bits, and the output exponent is the larger exponent plus one. Otherwise the raw sum and the larger exponent are output as they are.
- R7: Operand pairs may arrive on consecutive cycles, in any pattern of valid and idle cycles. Each result depends only on its own operand pair.
- R8: While `rst` is high, `out_vld`, `out_exp` and `out_sig` are all zero.
- R9: Carries cross every slice boundary (bit 47 to 48 and bit 95 to 96 at the defaults), including a ripple through the whole width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair valid |
| in_exp_a | input | EXP_W | Digit exponent of operand A |
| in_sig_a | input | SIG_W | Two's-complement significand of operand A |
| in_exp_b | input | EXP_W | Digit exponent of operand B |
| in_sig_b | input | SIG_W | Two's-complement significand of operand B |
| out_vld | output | 1 | Result valid |
| out_exp | output | EXP_W | Result digit exponent |
| out_sig | output | SIG_W | Result significand |

## Verification
Two functions of the block can act in the same cycle: the alignment shift of the smaller operand and the one-digit carry correction of the sum. A sum that crosses a slice boundary can also meet the correction in the same cycle. The bench provokes these cases with operand pairs that differ in exponent and still overflow, and with values near full scale that force the top slice to overflow after a carry ripples up from below. Every result is judged against a behavioural model that shifts bit by bit and detects overflow by a signed range compare. The model is checked on every clock, and this is done both in directed cases and in back-to-back random traffic.

// File: rtl/dga_pkg.sv
package dga_pkg;
  localparam int DEF_BASE_LG2 = 6;
  localparam int DEF_FP_EXP_W = 11;
  localparam int DEF_SLICE_W  = 48;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/dga_align.sv
module dga_align #(
  parameter int SIG_W    = 118,
  parameter int EXP_W    = 5,
  parameter int BASE_LG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_a,
  input  logic [SIG_W-1:0] sig_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic [SIG_W-1:0] sig_b,
  output logic [SIG_W-1:0] al_a,
  output logic [SIG_W-1:0] al_b,
  output logic [EXP_W-1:0] al_e
);
  localparam int DIGIT = 1 << BASE_LG2;
  localparam int MAXD  = dga_pkg::ceil_div(SIG_W, DIGIT);
  localparam int SHW   = EXP_W + BASE_LG2;

  logic                    a_big;
  logic [EXP_W-1:0]        diff;
  logic [SHW-1:0]          amt;
  logic signed [SIG_W-1:0] small_s;
  logic signed [SIG_W-1:0] sh_s;
  logic [SIG_W-1:0]        shifted;

  assign a_big   = (exp_a >= exp_b);
  assign diff    = a_big ? (exp_a - exp_b) : (exp_b - exp_a);
  assign amt     = SHW'(diff) << BASE_LG2;
  assign small_s = a_big ? sig_b : sig_a;
  assign sh_s    = small_s >>> amt;
  assign shifted = (int'(diff) >= MAXD) ? {SIG_W{small_s[SIG_W-1]}} : sh_s;

  assign al_a = a_big ? sig_a : shifted;
  assign al_b = a_big ? shifted : sig_b;
  assign al_e = a_big ? exp_a : exp_b;

  // R2
  emax_chk: assert property (@(posedge clk) disable iff (rst)
    (al_e >= exp_a) && (al_e >= exp_b) && ((al_e == exp_a) || (al_e == exp_b)));
  // R3
  keep_a_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_a >= exp_b) |-> (al_a == sig_a));
  // R3
  keep_b_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_b > exp_a) |-> (al_b == sig_b));
  // R4
  far_chk: assert property (@(posedge clk) disable iff (rst)
    ((int'(exp_a) - int'(exp_b)) >= MAXD) |-> (al_b == {SIG_W{sig_b[SIG_W-1]}}));
endmodule

// File: rtl/dga_slice_add.sv
module dga_slice_add #(
  parameter int SLICE_W = 48,
  parameter int WD      = 48
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout
);
  logic [WD:0] raw;

  assign raw  = {1'b0, a[WD-1:0]} + {1'b0, b[WD-1:0]} + {{WD{1'b0}}, cin};
  assign cout = raw[WD];

  if (WD < SLICE_W) begin : g_narrow
    logic unused_hi;
    assign unused_hi = ^{a[SLICE_W-1:WD], b[SLICE_W-1:WD]};
    assign sum = {{(SLICE_W-WD){1'b0}}, raw[WD-1:0]};
  end else begin : g_full
    assign sum = raw[WD-1:0];
  end
endmodule

// File: rtl/dga_carry_fix.sv
module dga_carry_fix #(
  parameter int SIG_W    = 118,
  parameter int EXP_W    = 5,
  parameter int BASE_LG2 = 6
) (
  input  logic [SIG_W-1:0] raw_sig,
  input  logic [EXP_W-1:0] raw_exp,
  output logic [SIG_W-1:0] fix_sig,
  output logic [EXP_W-1:0] fix_exp
);
  localparam int DIGIT = 1 << BASE_LG2;

  logic                    spill;
  logic signed [SIG_W-1:0] raw_s;
  logic signed [SIG_W-1:0] down_s;

  assign spill   = raw_sig[SIG_W-1] ^ raw_sig[SIG_W-2];
  assign raw_s   = raw_sig;
  assign down_s  = raw_s >>> DIGIT;
  assign fix_sig = spill ? down_s : raw_sig;
  assign fix_exp = spill ? (raw_exp + EXP_W'(1)) : raw_exp;
endmodule

// File: rtl/digit_align_add.sv
module digit_align_add #(
  parameter int BASE_LG2 = dga_pkg::DEF_BASE_LG2,
  parameter int FP_EXP_W = dga_pkg::DEF_FP_EXP_W,
  parameter int SLICE_W  = dga_pkg::DEF_SLICE_W,
  localparam int DIGIT   = 1 << BASE_LG2,
  localparam int SIG_W   = 54 + DIGIT,
  localparam int EXP_W   = FP_EXP_W - BASE_LG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [EXP_W-1:0] in_exp_a,
  input  logic [SIG_W-1:0] in_sig_a,
  input  logic [EXP_W-1:0] in_exp_b,
  input  logic [SIG_W-1:0] in_sig_b,
  output logic             out_vld,
  output logic [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0] out_sig
);
  localparam int NSLICE  = dga_pkg::ceil_div(SIG_W, SLICE_W);
  localparam int LAT     = NSLICE;
  localparam int LAST_LO = (NSLICE - 1) * SLICE_W;
  localparam int LAST_WD = SIG_W - LAST_LO;

  logic [SIG_W-1:0] al_a, al_b;
  logic [EXP_W-1:0] al_e;

  dga_align #(.SIG_W(SIG_W), .EXP_W(EXP_W), .BASE_LG2(BASE_LG2)) u_align (
    .clk(clk), .rst(rst),
    .exp_a(in_exp_a), .sig_a(in_sig_a),
    .exp_b(in_exp_b), .sig_b(in_sig_b),
    .al_a(al_a), .al_b(al_b), .al_e(al_e)
  );

  // stage inputs (index = slice handled in that stage)
  logic [SIG_W-1:0]   st_a   [NSLICE];
  logic [SIG_W-1:0]   st_b   [NSLICE];
  logic [SIG_W-1:0]   st_sum [NSLICE];
  logic               st_c   [NSLICE];
  logic [EXP_W-1:0]   st_e   [NSLICE];
  logic               st_v   [NSLICE];
  // slice adder results
  logic [SLICE_W-1:0] sl_sum [NSLICE];
  logic               sl_co  [NSLICE];
  // inter-stage registers
  logic [SIG_W-1:0]   r_a    [NSLICE-1];
  logic [SIG_W-1:0]   r_b    [NSLICE-1];
  logic [SIG_W-1:0]   r_sum  [NSLICE-1];
  logic               r_c    [NSLICE-1];
  logic [EXP_W-1:0]   r_e    [NSLICE-1];
  logic               r_v    [NSLICE-1];

  for (genvar s = 0; s < NSLICE; s++) begin : g_stage
    localparam int LO = s * SLICE_W;
    localparam int WD = (SIG_W - LO < SLICE_W) ? (SIG_W - LO) : SLICE_W;

    if (s == 0) begin : g_head
      assign st_a[s]   = al_a;
      assign st_b[s]   = al_b;
      assign st_sum[s] = '0;
      assign st_c[s]   = 1'b0;
      assign st_e[s]   = al_e;
      assign st_v[s]   = in_vld;
    end else begin : g_body
      assign st_a[s]   = r_a[s-1];
      assign st_b[s]   = r_b[s-1];
      assign st_sum[s] = r_sum[s-1];
      assign st_c[s]   = r_c[s-1];
      assign st_e[s]   = r_e[s-1];
      assign st_v[s]   = r_v[s-1];
    end

    dga_slice_add #(.SLICE_W(SLICE_W), .WD(WD)) u_add (
      .a(st_a[s][SLICE_W-1:0]), .b(st_b[s][SLICE_W-1:0]), .cin(st_c[s]),
      .sum(sl_sum[s]), .cout(sl_co[s])
    );

    if (s < NSLICE - 1) begin : g_reg
      // operands move down one slice per stage so the next slice sits at bit 0
      always_ff @(posedge clk) begin
        r_a[s]           <= st_a[s] >> SLICE_W;
        r_b[s]           <= st_b[s] >> SLICE_W;
        r_sum[s]         <= st_sum[s];
        r_sum[s][LO+:WD] <= sl_sum[s][WD-1:0];
        r_c[s]           <= sl_co[s];
        r_e[s]           <= st_e[s];
        if (rst) r_v[s] <= 1'b0;
        else     r_v[s] <= st_v[s];
      end
    end
  end

  logic [SIG_W-1:0] fin_sum;
  logic [SIG_W-1:0] fix_sig;
  logic [EXP_W-1:0] fix_exp;
  logic             unused_top_co;

  assign unused_top_co = sl_co[NSLICE-1];

  always_comb begin
    fin_sum = st_sum[NSLICE-1];
    fin_sum[SIG_W-1:LAST_LO] = sl_sum[NSLICE-1][LAST_WD-1:0];
  end

  dga_carry_fix #(.SIG_W(SIG_W), .EXP_W(EXP_W), .BASE_LG2(BASE_LG2)) u_fix (
    .raw_sig(fin_sum), .raw_exp(st_e[NSLICE-1]),
    .fix_sig(fix_sig), .fix_exp(fix_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_exp <= '0;
      out_sig <= '0;
    end else begin
      out_vld <= st_v[NSLICE-1];
      out_exp <= fix_exp;
      out_sig <= fix_sig;
    end
  end

  // checker support: cycles since reset, saturating at LAT
  int age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 0;
    else if (age < LAT) age <= age + 1;
  end

  // R1
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age == LAT) |-> (out_vld == $past(in_vld, LAT)));
  // R6
  norm_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_sig[SIG_W-1] == out_sig[SIG_W-2]));
  // R8
  rst_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld && (out_sig == '0) && (out_exp == '0)));
endmodule

// File: tb/digit_align_add_bench.sv
`timescale 1ns/1ps
module digit_align_add_bench;
  localparam int BASE_LG2 = 6;
  localparam int DIGIT    = 64;
  localparam int SIG_W    = 118;
  localparam int EXP_W    = 5;
  localparam int LAT      = 3;
  localparam logic signed [SIG_W-1:0] POS_LIM = {2'b00, {(SIG_W-2){1'b1}}};
  localparam logic signed [SIG_W-1:0] NEG_LIM = {2'b11, {(SIG_W-2){1'b0}}};

  typedef struct packed {
    logic             v;
    logic [EXP_W-1:0] e;
    logic [SIG_W-1:0] s;
  } res_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic [EXP_W-1:0] in_exp_a = '0, in_exp_b = '0;
  logic [SIG_W-1:0] in_sig_a = '0, in_sig_b = '0;
  logic             out_vld;
  logic [EXP_W-1:0] out_exp;
  logic [SIG_W-1:0] out_sig;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R8";
  res_t  pipe [LAT];
  string ptag [LAT];

  always #2.5 clk = ~clk;

  digit_align_add u_digit_align_add (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .in_exp_a(in_exp_a), .in_sig_a(in_sig_a),
    .in_exp_b(in_exp_b), .in_sig_b(in_sig_b),
    .out_vld(out_vld), .out_exp(out_exp), .out_sig(out_sig)
  );

  function automatic logic signed [SIG_W-1:0] shr_bits(logic signed [SIG_W-1:0] x, int n);
    logic signed [SIG_W-1:0] y = x;
    for (int i = 0; i < n && i < SIG_W + 1; i++) y = y >>> 1;
    return y;
  endfunction

  function automatic res_t model(logic v, logic [EXP_W-1:0] ea, logic [SIG_W-1:0] sa,
                                 logic [EXP_W-1:0] eb, logic [SIG_W-1:0] sb);
    res_t r;
    logic signed [SIG_W-1:0] xa = sa, xb = sb, sm;
    int big;
    if (int'(ea) >= int'(eb)) begin
      xb = shr_bits(xb, (int'(ea) - int'(eb)) * DIGIT); big = int'(ea);
    end else begin
      xa = shr_bits(xa, (int'(eb) - int'(ea)) * DIGIT); big = int'(eb);
    end
    sm = xa + xb;
    if (sm > POS_LIM || sm < NEG_LIM) begin
      sm = sm >>> DIGIT;
      big = big + 1;
    end
    r.v = v; r.e = EXP_W'(big); r.s = sm;
    return r;
  endfunction

  initial for (int i = 0; i < LAT; i++) begin pipe[i] = '0; ptag[i] = "R1"; end

  always @(posedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin pipe[i] = pipe[i-1]; ptag[i] = ptag[i-1]; end
    pipe[0] = model(in_vld && !rst, in_exp_a, in_sig_a, in_exp_b, in_sig_b);
    ptag[0] = tag;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (out_vld !== pipe[LAT-1].v) begin
        fails++;
        $display("FAIL R1 out_vld actual=%b expected=%b", out_vld, pipe[LAT-1].v);
      end else if (pipe[LAT-1].v) begin
        checks++;
        if (out_exp !== pipe[LAT-1].e || out_sig !== pipe[LAT-1].s) begin
          fails++;
          $display("FAIL %s exp actual=%0d expected=%0d sig actual=%h expected=%h",
                   ptag[LAT-1], out_exp, pipe[LAT-1].e, out_sig, pipe[LAT-1].s);
        end
      end
    end
  end

  task automatic put(input logic v, input int ea, input logic [SIG_W-1:0] sa,
                     input int eb, input logic [SIG_W-1:0] sb);
    @(negedge clk);
    in_vld = v; in_exp_a = EXP_W'(ea); in_sig_a = sa; in_exp_b = EXP_W'(eb); in_sig_b = sb;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 0, '0, 0, '0);
  endtask

  function automatic logic [SIG_W-1:0] rnd_sig();
    logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
    return {r[SIG_W-2], r[SIG_W-2:0]};
  endfunction

  localparam logic [SIG_W-1:0] ONE  = SIG_W'(1);
  localparam logic [SIG_W-1:0] MONE = {SIG_W{1'b1}};

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_sig !== '0 || out_exp !== '0) begin
      fails++;
      $display("FAIL R8 reset vld=%b exp=%0d sig=%h expected zeros", out_vld, out_exp, out_sig);
    end
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R3: one-digit shift both ways, equal exponents
    tag = "R3";
    put(1, 10, SIG_W'(128'h1234_5678_9abc_def0_1111), 9, SIG_W'(128'hffff_ffff_ffff_ffff_5555));
    put(1, 4, SIG_W'(128'h0777_0000_0000_0000_3333), 5, SIG_W'(128'h0000_0000_0000_0001_0000_0000));
    put(1, 7, SIG_W'(128'h55), 7, SIG_W'(128'h33));
    put(1, 7, MONE - SIG_W'(128'h1_0000_0000_0000_0000), 6, MONE);
    // R2: larger exponent chosen
    tag = "R2";
    put(1, 20, SIG_W'(5), 3, SIG_W'(7));
    put(1, 3, SIG_W'(5), 20, SIG_W'(7));
    // R4: far shifts give 0 or -1
    tag = "R4";
    put(1, 10, SIG_W'(1000), 7, MONE - SIG_W'(12345));
    put(1, 10, SIG_W'(1000), 7, SIG_W'(12345));
    put(1, 2, MONE - SIG_W'(99), 12, SIG_W'(77));
    put(1, 2, SIG_W'(77), 4, SIG_W'(99));
    // R9: carries across slice boundaries and full ripple
    tag = "R9";
    put(1, 6, {{(SIG_W-48){1'b0}}, {48{1'b1}}}, 6, ONE);
    put(1, 6, {{(SIG_W-96){1'b0}}, {96{1'b1}}}, 6, ONE);
    put(1, 6, MONE, 6, ONE);
    put(1, 6, {{(SIG_W-96){1'b1}}, {96{1'b0}}}, 6, MONE);
    // R6: overflow correction, positive, negative, at the limit, with shift
    tag = "R6";
    put(1, 8, {2'b00, {(SIG_W-2){1'b1}}}, 8, {2'b00, {(SIG_W-2){1'b1}}});
    put(1, 8, {2'b11, {(SIG_W-2){1'b0}}}, 8, {2'b11, {(SIG_W-2){1'b0}}});
    put(1, 8, {2'b00, {(SIG_W-2){1'b1}}}, 8, '0);
    put(1, 9, {2'b00, {(SIG_W-2){1'b1}}}, 8, {2'b00, {(SIG_W-2){1'b1}}});
    put(1, 9, {2'b00, {(SIG_W-2){1'b1}}}, 9, ONE);
    idle(4);

    // R5: random equal-exponent sums
    tag = "R5";
    for (int i = 0; i < 60; i++) begin
      int e = $urandom_range(0, 28);
      put(1, e, rnd_sig(), e, rnd_sig());
    end
    idle(4);

    // R1: valid spacing patterns
    tag = "R1";
    for (int i = 0; i < 40; i++) put(logic'(i % 3 == 0), i % 20, rnd_sig(), (i * 7) % 20, rnd_sig());
    idle(4);

    // R7: back-to-back mixed traffic
    tag = "R7";
    for (int i = 0; i < 400; i++)
      put(logic'($urandom_range(0, 3) != 0), $urandom_range(0, 28), rnd_sig(),
          $urandom_range(0, 28), rnd_sig());
    idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule